// File: doc/BRIEF.md
# Debounced Keypad Matrix Scanner

This block reads an 8-row by 10-column switch matrix and turns it into a stream of key events. While no key is down it drives every column at once and waits. When a row reports activity at a sample tick, it starts scanning: once per sample period it drives one column at a time, lets the row lines pass a two-flop synchronizer, and records a snapshot of all 80 switches.

Each key is debounced against its previous snapshot. A key is accepted as pressed when it reads closed in two successive snapshots. It is accepted as released when it reads open in two successive snapshots. Every accepted change produces one event: a one-cycle strobe with a press/release flag and a 7-bit key code. Changes found in the same snapshot come out on back-to-back cycles in ascending code order. After every key has been released, the scanner returns to idle.

The sample period is a number of system clock cycles set by a prescaler parameter. A 25 ms period is the intended setting in silicon; a short one is used in simulation.

Top module: `kpd_scanner`

## Requirements
- R1: The key at row r and column c (both counted from 0) has code r*10 + c + 1, in the range 1 to 80. Column drive and row inputs are active high. An event never carries code 0.
- R2: After reset, and while no key is accepted as down and the last snapshot was all open, all ten column lines are driven high and no event is produced. Scanning begins at the first sample tick at which a synchronized row line is high.
- R3: A press is accepted only after the key reads closed in two successive snapshots. A closure seen in a single snapshot produces no event.
- R4: A release is accepted only after the key reads open in two successive snapshots. An opening seen in a single snapshot while the key is held produces no event.
- R5: While scanning, at most one column line is high at a time. A held key is re-sampled every period without producing further events.
- R6: Changes accepted in the same snapshot are reported on consecutive clock cycles in ascending key-code order.
- R7: Releases accepted in different snapshots are reported in the order they were accepted, whatever their codes.
- R8: Once every key has been released and a snapshot reads all open, the scanner returns to idle, with all columns driven high.
- R9: `evt_valid` is high for one cycle per event. `evt_press` is 1 for a press and 0 for a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_in | input | 8 | Row sense lines, high when a driven column's switch is closed |
| col_drive | output | 10 | Column drive lines, active high |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_press | output | 1 | 1 = press, 0 = release |
| evt_code | output | 7 | Key code, 1 to 80 |

## Verification
The bench models the matrix and drives it against a scoreboard of expected events.

- **Short closure.** A closure shorter than one period is applied from idle. A scanner that accepted a single snapshot would report a phantom press.
- **Brief opening of a held key.** A held key is opened for one period. A scanner that released on one open snapshot would emit a spurious release, and probably a second press after it.
- **Simultaneous presses.** Keys in opposite corners and the middle of the matrix are pressed together. A wrong priority order or a gap between events shows up as an order or cycle mismatch.
- **Staggered releases.** Keys are released one at a time, in an order that is not ascending code order. A design that sorted events globally instead of per snapshot would report them in the wrong order.
- **Return to idle.** The bench checks that all columns are driven again after each key set has cleared. A scanner stuck in scanning would fail that check.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_EVAL,
      ST_EMIT,
      ST_WAIT
   } kpd_state_e;
endpackage

// File: rtl/kpd_tick.sv
module kpd_tick #(
   parameter int DIV = 200
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int TW = (DIV > 2) ? $clog2(DIV) : 1;

   logic [TW-1:0] cnt;

   if (DIV < 2) begin : g_bad_div
      $error("kpd_tick: DIV must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (cnt == TW'(DIV - 1))   cnt <= '0;
      else                            cnt <= cnt + TW'(1);
   end

   assign tick = (cnt == TW'(DIV - 1));

   // R5: sample ticks are isolated single-cycle pulses
   p_tick_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/kpd_sync.sv
module kpd_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("kpd_sync: at least two stages required");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce #(
   parameter int KEYS = 80
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            commit,
   input  logic [KEYS-1:0] cur,
   input  logic [KEYS-1:0] ack,
   output logic [KEYS-1:0] down,
   output logic [KEYS-1:0] pend
);
   logic [KEYS-1:0] prev;

   for (genvar k = 0; k < KEYS; k++) begin : g_key
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev[k] <= 1'b0;
            down[k] <= 1'b0;
            pend[k] <= 1'b0;
         end else if (commit) begin
            prev[k] <= cur[k];
            if (cur[k] && prev[k]) begin
               down[k] <= 1'b1;
               pend[k] <= !down[k];
            end else if (!cur[k] && !prev[k]) begin
               down[k] <= 1'b0;
               pend[k] <= down[k];
            end else begin
               pend[k] <= 1'b0;
            end
         end else if (ack[k]) begin
            pend[k] <= 1'b0;
         end
      end

      // R3: acceptance of a press needs the earlier snapshot closed too
      p_press_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(down[k]) |-> $past(prev[k]) && $past(cur[k]));
      // R4: acceptance of a release needs two open snapshots
      p_release_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(down[k]) |-> !$past(prev[k]) && !$past(cur[k]));
   end
endmodule

// File: rtl/kpd_prienc.sv
module kpd_prienc #(
   parameter int N  = 80,
   parameter int IW = 7
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign any = |vec;

   // R6: the chosen entry is set and no lower entry is set
   always_comb begin
      if (any) begin
         p_lowest_first_r6: assert (vec[idx] &&
            ((vec & ((N'(1) << idx) - N'(1))) == '0));
      end
   end
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
   import kpd_pkg::*;
#(
   parameter int ROWS        = 8,
   parameter int COLS        = 10,
   parameter int TICK_DIV    = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [ROWS-1:0]                     row_in,
   output logic [COLS-1:0]                     col_drive,
   output logic                                evt_valid,
   output logic                                evt_press,
   output logic [$clog2(ROWS*COLS+1)-1:0]      evt_code
);
   localparam int KEYS   = ROWS * COLS;
   localparam int KW     = $clog2(KEYS);
   localparam int CW     = $clog2(KEYS + 1);
   localparam int CIW    = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int SETTLE = SYNC_STAGES + 1;
   localparam int SLW    = $clog2(SETTLE + 1);

   if (TICK_DIV < COLS * SETTLE + KEYS + 8) begin : g_bad_period
      $error("kpd_scanner: TICK_DIV too short for one scan plus event drain");
   end
   if (ROWS < 1 || COLS < 2) begin : g_bad_geom
      $error("kpd_scanner: matrix needs at least one row and two columns");
   end

   kpd_state_e       st;
   logic [CIW-1:0]   col;
   logic [SLW-1:0]   stl;
   logic [KEYS-1:0]  cur;
   logic [KEYS-1:0]  down, pend, ack;
   logic [ROWS-1:0]  rows_s;
   logic [KW-1:0]    pidx;
   logic             pany, tick, commit;

   kpd_sync #(.W(ROWS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(row_in), .q(rows_s));

   kpd_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   kpd_debounce #(.KEYS(KEYS)) u_deb (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cur(cur), .ack(ack),
      .down(down), .pend(pend));

   kpd_prienc #(.N(KEYS), .IW(KW)) u_pe (
      .vec(pend), .idx(pidx), .any(pany));

   assign commit = (st == ST_EVAL);
   assign ack    = (st == ST_EMIT && pany) ? (KEYS'(1) << pidx) : '0;

   always_comb begin
      unique case (st)
         ST_IDLE: col_drive = '1;
         ST_SCAN: col_drive = COLS'(1) << col;
         default: col_drive = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         col       <= '0;
         stl       <= '0;
         cur       <= '0;
         evt_valid <= 1'b0;
         evt_press <= 1'b0;
         evt_code  <= '0;
      end else begin
         evt_valid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (tick && |rows_s) begin
                  st  <= ST_SCAN;
                  col <= '0;
                  stl <= '0;
               end
            end
            ST_SCAN: begin
               if (stl == SLW'(SETTLE - 1)) begin
                  for (int r = 0; r < ROWS; r++) begin
                     cur[KW'(r * COLS) + KW'(col)] <= rows_s[r];
                  end
                  stl <= '0;
                  if (col == CIW'(COLS - 1)) begin
                     col <= '0;
                     st  <= ST_EVAL;
                  end else begin
                     col <= col + CIW'(1);
                  end
               end else begin
                  stl <= stl + SLW'(1);
               end
            end
            ST_EVAL: st <= ST_EMIT;
            ST_EMIT: begin
               if (pany) begin
                  evt_valid <= 1'b1;
                  evt_press <= down[pidx];
                  evt_code  <= CW'(pidx) + CW'(1);
               end else if (down == '0 && cur == '0) begin
                  st <= ST_IDLE;
               end else begin
                  st <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tick) begin
                  st  <= ST_SCAN;
                  col <= '0;
                  stl <= '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R1: emitted codes stay inside 1..KEYS
   p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_code != '0) && (evt_code <= CW'(KEYS)));
   // R5: outside idle at most one column is driven
   p_one_column_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_drive != '1) |-> $onehot0(col_drive));
   // R6: back-to-back events rise strictly in code
   p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && $past(evt_valid)) |-> (evt_code > $past(evt_code)));
   // R2: no event while all columns are driven in idle
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (col_drive == '1) |-> !evt_valid);
endmodule

// File: tb/test_kpd_scanner.sv
`timescale 1ns/1ps
module test_kpd_scanner;
   localparam int ROWS = 8;
   localparam int COLS = 10;
   localparam int TICK = 200;

   typedef struct {
      logic  press;
      int    code;
      string tag;
      bit    consec;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ROWS-1:0]   row_in;
   logic [COLS-1:0]   col_drive;
   logic              evt_valid, evt_press;
   logic [6:0]        evt_code;

   bit    keys [ROWS][COLS];
   exp_t  exp_q [$];
   int    n_cmp = 0, n_bad = 0;
   int    cyc = 0, last_evt = -10;
   bit    done = 1'b0;

   always #2 clk = ~clk;

   kpd_scanner #(.ROWS(ROWS), .COLS(COLS), .TICK_DIV(TICK)) i_kpd_scanner (
      .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_drive(col_drive),
      .evt_valid(evt_valid), .evt_press(evt_press), .evt_code(evt_code));

   always_comb begin
      for (int r = 0; r < ROWS; r++) begin
         row_in[r] = 1'b0;
         for (int c = 0; c < COLS; c++) begin
            if (keys[r][c] && col_drive[c]) row_in[r] = 1'b1;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic push(logic press, int r, int c, string tag, bit consec);
      exp_t e;
      e.press  = press;
      e.code   = r * COLS + c + 1;
      e.tag    = tag;
      e.consec = consec;
      exp_q.push_back(e);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic periods(int n);
      repeat (n * TICK) @(posedge clk);
   endtask

   // change the matrix only while no scan is in progress
   task automatic safe_point();
      @(negedge clk);
      while (!(col_drive == '0 || col_drive == '1)) @(negedge clk);
   endtask

   // monitor: compare each strobe with the head of the queue
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && evt_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected event code", int'(evt_code), 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(evt_code) == e.code, e.tag, "event code", int'(evt_code), e.code);
            chk(evt_press == e.press, "R9", "press flag", int'(evt_press), int'(e.press));
            if (e.consec)
               chk(cyc == last_evt + 1, e.tag, "consecutive cycle gap", cyc - last_evt, 1);
         end
         last_evt = cyc;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R2", "watchdog expired", cyc, 0);
      summary();
   end

   initial begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) keys[r][c] = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      chk(col_drive == '1, "R2", "idle column drive", int'(col_drive), 1023);
      chk(evt_valid == 1'b0, "R9", "no strobe after reset", int'(evt_valid), 0);
      periods(3);
      @(negedge clk);
      chk(col_drive == '1, "R2", "stays idle with no key", int'(col_drive), 1023);

      // R3: closure shorter than a period is rejected
      keys[2][3] = 1'b1;
      repeat (60) @(posedge clk);
      keys[2][3] = 1'b0;
      periods(4);
      @(negedge clk);
      chk(col_drive == '1, "R3", "idle after rejected glitch", int'(col_drive), 1023);

      // R1: corner key (0,0) is code 1
      push(1'b1, 0, 0, "R1", 1'b0);
      keys[0][0] = 1'b1;
      periods(4);
      @(negedge clk);
      chk(col_drive != '1, "R5", "scanning while held", int'(col_drive), 0);
      periods(5);
      safe_point();
      push(1'b0, 0, 0, "R4", 1'b0);
      keys[0][0] = 1'b0;
      periods(4);
      @(negedge clk);
      chk(col_drive == '1, "R8", "idle after release", int'(col_drive), 1023);

      // R6: simultaneous presses in ascending order, back to back
      push(1'b1, 1, 0, "R6", 1'b0);
      push(1'b1, 3, 4, "R6", 1'b1);
      push(1'b1, 7, 9, "R1", 1'b1);
      keys[7][9] = 1'b1;
      keys[3][4] = 1'b1;
      keys[1][0] = 1'b1;
      periods(4);

      // R7: staggered releases in detection order, not code order
      safe_point();
      push(1'b0, 3, 4, "R7", 1'b0);
      keys[3][4] = 1'b0;
      periods(3);
      safe_point();
      push(1'b0, 7, 9, "R7", 1'b0);
      keys[7][9] = 1'b0;
      periods(3);
      safe_point();
      push(1'b0, 1, 0, "R7", 1'b0);
      keys[1][0] = 1'b0;
      periods(4);
      @(negedge clk);
      chk(col_drive == '1, "R8", "idle after staggered releases", int'(col_drive), 1023);

      // R4: one-period opening of a held key is ignored
      push(1'b1, 0, 4, "R6", 1'b0);
      push(1'b1, 6, 1, "R6", 1'b1);
      keys[0][4] = 1'b1;
      keys[6][1] = 1'b1;
      periods(4);
      safe_point();
      keys[6][1] = 1'b0;
      repeat (TICK) @(posedge clk);
      keys[6][1] = 1'b1;
      periods(4);
      @(negedge clk);
      chk(exp_q.size() == 0, "R4", "pending events after brief opening", exp_q.size(), 0);

      // R6: simultaneous releases, ascending and back to back
      safe_point();
      push(1'b0, 0, 4, "R6", 1'b0);
      push(1'b0, 6, 1, "R6", 1'b1);
      keys[0][4] = 1'b0;
      keys[6][1] = 1'b0;
      periods(4);
      @(negedge clk);
      chk(col_drive == '1, "R8", "idle at end", int'(col_drive), 1023);
      chk(exp_q.size() == 0, "R5", "expected events left unseen", exp_q.size(), 0);
      summary();
   end
endmodule